// File: doc/BRIEF.md
# Frame Header Break and Baud Detector

This block watches the received line of a single-wire master/slave bus, sampled on a free-running local clock that need not be precise. Every frame header opens with a long dominant (low) break, then a recessive delimiter, then a synchronisation byte of alternating bits. The block spots the break, checks the delimiter and times the interval between two rising edges of the synchronisation byte. Half that interval is the sender's bit period in local clock cycles. It is published on `bit_time` so that a UART receiver can sample the bytes that follow without a fixed divisor.

The block is built around one state machine. Its states are `ST_IDLE` (no header seen yet), `ST_BREAK` (qualifying low run in progress), `ST_DELIM` (recessive delimiter being timed), `ST_SYNC_START` (start bit of the sync byte), `ST_MEASURE` (timing from the first to the second rising edge), `ST_LOCKED` (valid header, period held) and `ST_FAULT` (header rejected). These are the transitions. Any state goes to `ST_BREAK` on a qualifying break, and any state goes to `ST_IDLE` when `en` is low. `ST_BREAK` goes to `ST_DELIM` on a rising edge. `ST_DELIM` goes to `ST_SYNC_START` on a falling edge after a long enough delimiter, and to `ST_FAULT` on a falling edge after a short one. `ST_SYNC_START` goes to `ST_MEASURE` on a rising edge. `ST_MEASURE` goes to `ST_LOCKED` when the measured period is inside the tolerance window, and to `ST_FAULT` when it is outside. `ST_SYNC_START` and `ST_MEASURE` both go to `ST_FAULT` when the edge they wait for never arrives.

Parameters set the nominal bit period in local cycles (`NOM_BIT_CLKS`), the break threshold in nominal bits (`BRK_BITS`, default 11) and the tolerance in percent (`TOL_PCT`, default 15). Derived values: BIT_MIN = NOM_BIT_CLKS*(100-TOL_PCT)/100, BIT_MAX = NOM_BIT_CLKS*(100+TOL_PCT)/100 (integer division), BRK_MIN = BRK_BITS*NOM_BIT_CLKS.

Top module: `lin_brk_sync`

## Requirements
- R1: After a synchronous active-high `rst`, `bit_time` is 0 and `header_start` and `sync_err` are 0.
- R2: A break is recognised once `bus_rx` has been sampled low on BRK_MIN consecutive clocks while `en` is high. A low run of BRK_MIN-1 samples is not a break, and the sync pattern after it produces no output event. A 13-bit break seen by a node whose clock runs 15% slow is still at least BRK_MIN samples long, so it is accepted.
- R3: The recessive delimiter after a break must be sampled high on at least BIT_MIN clocks before the next falling edge. A shorter delimiter raises `sync_err`.
- R4: The sync byte is 0x55 sent LSB first, framed by a low start bit and a high stop bit. The first rising edge is the start of data bit 0 and the second is the start of data bit 2. `bit_time` is the number of clocks between these two rising-edge samples, divided by 2.
- R5: When BIT_MIN <= bit_time <= BIT_MAX, the header is accepted. Otherwise `sync_err` is raised, `bit_time` keeps its previous value and `header_start` does not pulse. `header_start` and `sync_err` are never high together.
- R6: On an accepted header, `header_start` is high for exactly one clock: the clock after the second rising edge is sampled. The new `bit_time` is valid in that same clock.
- R7: `bit_time` changes only in a clock where `header_start` is high. Bus traffic after a valid header that contains no qualifying break, such as a 0x00 data byte, causes no event and leaves `bit_time` unchanged.
- R8: A qualifying break rearms the detector from any state, including partway through a sync byte and after a rejected header. It also clears `sync_err`.
- R9: While `en` is low the detector is held idle. In the clock after `en` is sampled low, `header_start` and `sync_err` are 0, and a header sent while `en` is low produces no event.
- R10: If `ST_SYNC_START` or `ST_MEASURE` waits more than 2*BIT_MAX clocks without the rising edge it expects, `sync_err` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Detector enable; low holds it idle |
| bus_rx | input | 1 | Bus line, already synchronised to clk (0 = dominant) |
| bit_time | output | BTW | Measured bit period in clk cycles |
| header_start | output | 1 | One-clock strobe on an accepted header |
| sync_err | output | 1 | Header rejected; held until the next break or disable |

## Verification
The bench sends breaks of exactly BRK_MIN and BRK_MIN-1 samples. A detector with the comparison off by one would either accept the short run or miss the exact one. Sync periods at BIT_MIN, BIT_MAX and one cycle beyond each end check the inclusive window. A wrong divide or a wrong edge pair shows up as a `bit_time` of 2x or 1x the period. A delimiter one cycle short of BIT_MIN and a start bit stretched into a fresh break check the fault and rearm paths. A detector that failed to clear its error, or that stayed stuck, would drop the header that follows. A 0x00 data byte after lock and a header sent while disabled must leave `bit_time` unchanged and produce no event.

// File: rtl/lin_brk_sync_pkg.sv
package lin_brk_sync_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_DELIM,
        ST_SYNC_START,
        ST_MEASURE,
        ST_LOCKED,
        ST_FAULT
    } det_state_t;

endpackage

// File: rtl/lin_bus_edge.sv
module lin_bus_edge (
    input  logic clk,
    input  logic rst,
    input  logic line,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= line;
    end

    assign rise = line & ~prev_q;
    assign fall = ~line & prev_q;
endmodule

// File: rtl/lin_low_run.sv
module lin_low_run #(
    parameter int RUN_MIN = 220,
    parameter int CW      = $clog2(RUN_MIN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic line,
    output logic hit
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en || line)
            cnt_q <= '0;
        else if (cnt_q != CW'(RUN_MIN))
            cnt_q <= cnt_q + 1'b1;
    end

    // this cycle is the RUN_MIN-th consecutive low sample
    assign hit = en && !line && (cnt_q == CW'(RUN_MIN - 1));
endmodule

// File: rtl/lin_span_timer.sv
module lin_span_timer #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [SW-1:0] span
);
    always_ff @(posedge clk) begin
        if (rst)
            span <= '0;
        else if (clr)
            span <= SW'(1);
        else if (span != {SW{1'b1}})
            span <= span + 1'b1;
    end
endmodule

// File: rtl/lin_brk_sync.sv
module lin_brk_sync
    import lin_brk_sync_pkg::*;
#(
    parameter int NOM_BIT_CLKS = 400,
    parameter int BRK_BITS     = 11,
    parameter int TOL_PCT      = 15,
    parameter int BTW          = $clog2(NOM_BIT_CLKS * (100 + TOL_PCT) / 100 + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           bus_rx,
    output logic [BTW-1:0] bit_time,
    output logic           header_start,
    output logic           sync_err
);
    localparam int BIT_MIN  = NOM_BIT_CLKS * (100 - TOL_PCT) / 100;
    localparam int BIT_MAX  = NOM_BIT_CLKS * (100 + TOL_PCT) / 100;
    localparam int BRK_MIN  = BRK_BITS * NOM_BIT_CLKS;
    localparam int SPAN_MIN = 2 * BIT_MIN;
    localparam int SPAN_MAX = 2 * BIT_MAX;
    localparam int SW       = $clog2(SPAN_MAX + 2);

    det_state_t    state_q, state_d;
    logic          rise, fall, brk_hit, span_clr;
    logic [SW-1:0] span;
    logic          win_ok, accept;

    lin_bus_edge i_edge (
        .clk  (clk),
        .rst  (rst),
        .line (bus_rx),
        .rise (rise),
        .fall (fall)
    );

    lin_low_run #(.RUN_MIN(BRK_MIN)) i_low_run (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .line (bus_rx),
        .hit  (brk_hit)
    );

    lin_span_timer #(.SW(SW)) i_span (
        .clk  (clk),
        .rst  (rst),
        .clr  (span_clr),
        .span (span)
    );

    assign win_ok = (span >= SW'(SPAN_MIN)) && (span <= SW'(SPAN_MAX));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else if (brk_hit) begin
            state_d = ST_BREAK;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_BREAK:      if (rise) state_d = ST_DELIM;
                ST_DELIM:      if (fall)
                                   state_d = (span >= SW'(BIT_MIN)) ? ST_SYNC_START : ST_FAULT;
                ST_SYNC_START: if (rise)
                                   state_d = ST_MEASURE;
                               else if (span > SW'(SPAN_MAX))
                                   state_d = ST_FAULT;
                ST_MEASURE:    if (rise)
                                   state_d = win_ok ? ST_LOCKED : ST_FAULT;
                               else if (span > SW'(SPAN_MAX))
                                   state_d = ST_FAULT;
                ST_LOCKED:     state_d = ST_LOCKED;
                ST_FAULT:      state_d = ST_FAULT;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    assign span_clr = (state_d != state_q);
    assign accept   = (state_q == ST_MEASURE) && (state_d == ST_LOCKED);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_time     <= '0;
            header_start <= 1'b0;
            sync_err     <= 1'b0;
        end else begin
            header_start <= accept;
            sync_err     <= (state_d == ST_FAULT);
            if (accept)
                bit_time <= BTW'(span >> 1);
        end
    end
endmodule

// File: rtl/lin_brk_sync_chk.sv
module lin_brk_sync_chk #(
    parameter int BIT_MIN = 1,
    parameter int BIT_MAX = 1,
    parameter int BTW     = 1
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic           header_start,
    input logic           sync_err,
    input logic [BTW-1:0] bit_time
);
    AST_HS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        header_start |=> !header_start); // R6

    AST_HS_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(header_start && sync_err)); // R5

    AST_BT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        header_start |-> (bit_time >= BTW'(BIT_MIN)) && (bit_time <= BTW'(BIT_MAX))); // R5

    AST_BT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !header_start |-> $stable(bit_time)); // R7

    AST_EN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!header_start && !sync_err)); // R9
endmodule

bind lin_brk_sync lin_brk_sync_chk #(
    .BIT_MIN (BIT_MIN),
    .BIT_MAX (BIT_MAX),
    .BTW     (BTW)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .header_start (header_start),
    .sync_err     (sync_err),
    .bit_time     (bit_time)
);

// File: tb/test_lin_brk_sync.sv
module test_lin_brk_sync;
    localparam int NOM     = 20;
    localparam int BIT_MIN = NOM * 85 / 100;   // 17
    localparam int BIT_MAX = NOM * 115 / 100;  // 23
    localparam int BRK_MIN = 11 * NOM;         // 220
    localparam int BTW     = $clog2(BIT_MAX + 1);

    typedef struct { bit ok; int bt; string tag; } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           en  = 1'b1;
    logic           bus = 1'b1;
    logic [BTW-1:0] bit_time;
    logic           header_start, sync_err;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   done    = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    lin_brk_sync #(.NOM_BIT_CLKS(NOM), .BRK_BITS(11), .TOL_PCT(15)) i_lin_brk_sync (
        .clk(clk), .rst(rst), .en(en), .bus_rx(bus),
        .bit_time(bit_time), .header_start(header_start), .sync_err(sync_err)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input bit v, input int n);
        bus = v;
        repeat (n) @(negedge clk);
    endtask

    // sync byte 0x55: start, LSB-first data, stop
    task automatic send_sync(input int b);
        hold(1'b0, b);
        for (int i = 0; i < 8; i++) hold(((8'h55 >> i) & 1) != 0, b);
        hold(1'b1, b);
    endtask

    task automatic send_header(input int brk, input int dl, input int b);
        hold(1'b0, brk);
        hold(1'b1, dl);
        send_sync(b);
        hold(1'b1, 3 * NOM);
    endtask

    task automatic expect_ev(input bit ok, input int bt, input string tag);
        exp_t e;
        e.ok = ok; e.bt = bt; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: pops expected items as events appear
    logic err_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (header_start || (sync_err && !err_prev)) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected event", header_start ? 1 : 2, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(header_start == e.ok, e.tag, header_start ? 1 : 2, e.ok ? 1 : 2);
                    if (header_start && e.ok)
                        check(int'(bit_time) == e.bt, e.tag, int'(bit_time), e.bt);
                end
            end
            err_prev <= sync_err;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic drained(input string tag);
        check(q.size() == 0, tag, q.size(), 0);
    endtask

    initial begin
        int bt_before;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(bit_time == 0, "R1 bit_time", int'(bit_time), 0);
        check(header_start == 0, "R1 header_start", int'(header_start), 0);
        check(sync_err == 0, "R1 sync_err", int'(sync_err), 0);

        // R4 nominal header
        expect_ev(1'b1, 20, "R4 nominal");
        send_header(13 * NOM, NOM, 20);
        drained("R4 nominal drained");

        // R5 window edges
        expect_ev(1'b1, BIT_MIN, "R5 low edge");
        send_header(13 * NOM, NOM, BIT_MIN);
        expect_ev(1'b1, BIT_MAX, "R5 high edge");
        send_header(13 * NOM, NOM, BIT_MAX);
        expect_ev(1'b0, 0, "R5 too fast");
        send_header(13 * NOM, NOM, BIT_MIN - 1);
        check(int'(bit_time) == BIT_MAX, "R5 bit_time kept", int'(bit_time), BIT_MAX);
        // R8 break clears sync_err then slow period rejected
        expect_ev(1'b0, 0, "R5 too slow");
        send_header(13 * NOM, NOM, BIT_MAX + 1);
        drained("R5 drained");

        // R2 break threshold: exact, one short, slow-clock 13-bit break
        expect_ev(1'b1, 21, "R2 exact threshold");
        send_header(BRK_MIN, NOM, 21);
        check(sync_err == 0, "R8 sync_err cleared", int'(sync_err), 0);
        send_header(BRK_MIN - 1, NOM, 19);
        check(int'(bit_time) == 21, "R2 short break ignored", int'(bit_time), 21);
        expect_ev(1'b1, 19, "R2 slow-node break");
        send_header(13 * NOM * 85 / 100, NOM, 19);
        drained("R2 drained");

        // R3 delimiter boundary
        expect_ev(1'b1, 22, "R3 delimiter at min");
        send_header(13 * NOM, BIT_MIN, 22);
        expect_ev(1'b0, 0, "R3 delimiter short");
        send_header(13 * NOM, BIT_MIN - 1, 20);
        drained("R3 drained");

        // R7 data byte 0x00 after lock is ignored
        expect_ev(1'b1, 20, "R7 lock");
        send_header(13 * NOM, NOM, 20);
        bt_before = int'(bit_time);
        hold(1'b0, 9 * NOM);
        hold(1'b1, 2 * NOM);
        check(int'(bit_time) == bt_before, "R7 bit_time held", int'(bit_time), bt_before);
        drained("R7 drained");

        // R10 and R8: start bit stretched into a new break, then valid sync
        expect_ev(1'b0, 0, "R10 stuck start bit");
        expect_ev(1'b1, 18, "R8 rearm after stuck");
        hold(1'b0, 13 * NOM);
        hold(1'b1, NOM);
        hold(1'b0, 13 * NOM);
        hold(1'b1, NOM);
        send_sync(18);
        hold(1'b1, 3 * NOM);
        drained("R8 drained");

        // R8 rearm from locked state mid-frame
        expect_ev(1'b1, 23, "R8 rearm from lock");
        hold(1'b0, 4 * NOM);
        send_header(13 * NOM, NOM, 23);
        drained("R8 lock drained");

        // R9 disabled: no event
        en = 1'b0;
        @(negedge clk);
        check(header_start == 0 && sync_err == 0, "R9 quiet", int'(sync_err), 0);
        send_header(13 * NOM, NOM, 20);
        check(int'(bit_time) == 23, "R9 bit_time kept", int'(bit_time), 23);
        en = 1'b1;
        expect_ev(1'b1, 20, "R9 re-enabled");
        send_header(13 * NOM, NOM, 20);
        drained("R9 drained");

        // R6 strobe width
        expect_ev(1'b1, 17, "R6 strobe");
        fork
            send_header(13 * NOM, NOM, 17);
            begin
                @(posedge header_start);
                @(negedge clk);
                @(negedge clk);
                check(header_start == 0, "R6 one cycle", int'(header_start), 0);
            end
        join
        drained("R6 drained");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule